// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block turns a channel number into the external-memory word address of that channel's reassembly circular buffer. There are 32 TDM channels. Each one has a 10-bit control entry that holds both the buffer position and the buffer length. The length is marked by the lowest set bit among the entry's five low bits. The bits above that marker give the buffer's aligned start. A global base value supplies the top address bits.

Each channel also has a read pointer. An access request to a channel emits the buffer start with the pointer placed in the low bits, then advances that pointer. The pointer wraps to zero at the end of the decoded length. A control entry with no marker bit is malformed: it raises an error with the valid strobe and leaves the pointer where it was. Writing an entry restarts that channel's pointer at zero.

Top module: `cbuf_addr_gen`

## Requirements
- R1: The length marker is the lowest set bit k of entry bits 4..0, and it gives a buffer length of 64<<k entries (k=0 is 64, k=4 is 1024). Entry bits above k never change the decoded length.
- R2: For a well-formed entry, `addr_o` is laid out as follows: `base_i` in the top 7 bits, then entry bits 9..k+1, then a (6+k)-bit field that holds the channel's pointer. The address is 22 bits wide.
- R3: Each well-formed request advances that channel's pointer by one. After the pointer reaches length-1, the next request wraps it to 0.
- R4: Every channel keeps its own pointer. A request to one channel leaves every other channel's pointer unchanged.
- R5: `valid_o` is high in the cycle right after a cycle with `req` high, and it is low in the cycle after a cycle with `req` low.
- R6: When entry bits 4..0 are all zero, the request returns `err_o`=1 together with `valid_o`, and `addr_o` is all zeros. That channel's pointer does not move. `err_o` is low whenever the request was well-formed or no request was made.
- R7: A `cfg_we` cycle stores `cfg_fld` as the entry for `cfg_ch` and sets that channel's pointer to 0. A request in that same cycle uses the previous entry and pointer, and the pointer still ends at 0.
- R8: After reset every entry is zero, so every channel is malformed. All pointers are 0, and `valid_o`, `err_o` and `addr_o` are low.
- R9: `base_i` is sampled in the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_i | input | 7 | Global base, the top address bits |
| cfg_we | input | 1 | Control entry write enable |
| cfg_ch | input | 5 | Channel whose entry is written |
| cfg_fld | input | 10 | Address-and-size entry value |
| req | input | 1 | Access request |
| req_ch | input | 5 | Channel being accessed |
| addr_o | output | 22 | Registered word address |
| valid_o | output | 1 | Address valid, one cycle after `req` |
| err_o | output | 1 | Malformed entry, qualified by `valid_o` |

## Verification
The bench programs all five marker positions. It uses both all-ones and all-zeros upper entry bits, which shows whether the decode looks only at the lowest marker and whether the start bits are placed exactly above the pointer field. A long run of requests to one 64-entry channel, plus a partial run on a 1024-entry channel, exposes an off-by-one in the wrap. A random mix follows, with interleaved channels, rewrites, changing base values and malformed entries. That mix separates per-channel pointer state from shared state, and it checks that a write wins over a request in the same cycle.

// File: rtl/cbuf_addr_gen.sv
module cbuf_addr_gen #(
  parameter int NCH     = 32,
  parameter int BASE_W  = 7,
  parameter int FLD_W   = 10,
  parameter int NSZ     = 5,
  parameter int MIN_LOG = 6,
  localparam int CH_W   = $clog2(NCH),
  localparam int LOW_W  = FLD_W + MIN_LOG - 1,
  localparam int ADDR_W = BASE_W + LOW_W,
  localparam int PTR_W  = MIN_LOG + NSZ - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] base_i,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [FLD_W-1:0]  cfg_fld,
  input  logic              req,
  input  logic [CH_W-1:0]   req_ch,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              err_o
);

  logic [FLD_W-1:0] fld_q [NCH];
  logic [PTR_W-1:0] ptr_q [NCH];

  wire [FLD_W-1:0] sel_fld = fld_q[req_ch];
  wire [PTR_W-1:0] sel_ptr = ptr_q[req_ch];
  wire             bad     = (sel_fld[NSZ-1:0] == '0);

  logic [LOW_W-1:0] span_m1;
  logic             found;

  always_comb begin
    span_m1 = '0;
    found   = 1'b0;
    for (int k = 0; k < NSZ; k++) begin
      if (!found && sel_fld[k]) begin
        found   = 1'b1;
        span_m1 = LOW_W'((1 << (MIN_LOG + k)) - 1);
      end
    end
  end

  wire [LOW_W-1:0] start_low = {sel_fld, {(MIN_LOG-1){1'b0}}} & ~span_m1;
  wire [LOW_W-1:0] addr_low  = start_low | LOW_W'(sel_ptr);
  wire             at_end    = (sel_ptr == span_m1[PTR_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        fld_q[c] <= '0;
        ptr_q[c] <= '0;
      end
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      addr_o  <= '0;
    end else begin
      valid_o <= req;
      err_o   <= req & bad;
      if (req) begin
        if (bad) begin
          addr_o <= '0;
        end else begin
          addr_o         <= {base_i, addr_low};
          ptr_q[req_ch]  <= at_end ? '0 : sel_ptr + 1'b1;
        end
      end
      if (cfg_we) begin
        fld_q[cfg_ch] <= cfg_fld;
        ptr_q[cfg_ch] <= '0;
      end
    end
  end

  a_r5_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> valid_o);
  a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !valid_o);
  a_r6_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> valid_o);
  a_r6_err_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (addr_o == '0));
  a_r9_base_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !err_o) |-> (addr_o[ADDR_W-1 -: BASE_W] == $past(base_i)));
  a_r7_write_clears_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (ptr_q[$past(cfg_ch)] == '0));

endmodule

// File: tb/cbuf_addr_gen_test.sv
module cbuf_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  base_i = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_ch = '0;
  logic [9:0]  cfg_fld = '0;
  logic        req = 1'b0;
  logic [4:0]  req_ch = '0;
  logic [21:0] addr_o;
  logic        valid_o, err_o;

  int total = 0, bad = 0;
  logic [9:0] fld_m [32];
  int         ptr_m [32];

  always #4 clk = ~clk;

  cbuf_addr_gen uut (.clk, .rst_n, .base_i, .cfg_we, .cfg_ch, .cfg_fld,
                     .req, .req_ch, .addr_o, .valid_o, .err_o);

  function automatic int log_len(logic [9:0] f);
    for (int k = 0; k < 5; k++) if (f[k]) return 6 + k;
    return 0;
  endfunction

  function automatic logic [21:0] exp_addr(logic [6:0] b, logic [9:0] f, int p);
    int L = log_len(f);
    logic [21:0] hi;
    hi = 22'({b, f} >> (L - 5));
    return (hi << L) | 22'(p);
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step(bit we, int wc, logic [9:0] wf, bit rq, int rc, logic [6:0] b, string r);
    logic [21:0] ea = '0;
    bit ee = 0;
    @(negedge clk);
    cfg_we = we; cfg_ch = 5'(wc); cfg_fld = wf;
    req = rq; req_ch = 5'(rc); base_i = b;
    if (rq) begin
      if (fld_m[rc][4:0] == 0) ee = 1;
      else begin
        ea = exp_addr(b, fld_m[rc], ptr_m[rc]);
        ptr_m[rc] = (ptr_m[rc] == (1 << log_len(fld_m[rc])) - 1) ? 0 : ptr_m[rc] + 1;
      end
    end
    if (we) begin fld_m[wc] = wf; ptr_m[wc] = 0; end
    @(posedge clk); #1;
    cfg_we = 0; req = 0;
    chk({r, " R5 valid"}, 32'(valid_o), 32'(rq));
    if (rq) begin
      chk({r, " R6 err"}, 32'(err_o), 32'(ee));
      chk({r, " R2 addr"}, 32'(addr_o), 32'(ea));
    end else chk({r, " R6 err idle"}, 32'(err_o), 0);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    for (int c = 0; c < 32; c++) begin fld_m[c] = '0; ptr_m[c] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset valid", 32'(valid_o), 0);
    chk("R8 reset err", 32'(err_o), 0);
    chk("R8 reset addr", 32'(addr_o), 0);
    @(negedge clk); rst_n = 1;
    for (int c = 0; c < 32; c += 7) step(0, 0, 0, 1, c, 7'h55, "R8 empty entry");

    // R1 R2: every marker, upper bits all ones and all zeros
    for (int k = 0; k < 5; k++) begin
      step(1, k, 10'h3FF << k & 10'h3FF | 10'(1 << k), 0, 0, 0, "R1 write");
      step(0, 0, 0, 1, k, 7'h7F, "R1 ones");
      step(1, 10 + k, 10'(1 << k), 0, 0, 0, "R1 write0");
      step(0, 0, 0, 1, 10 + k, 7'h2A, "R2 zeros");
    end
    // R3 wrap on 64-entry buffer
    step(1, 20, 10'b1010110101, 0, 0, 0, "R3 setup");
    for (int i = 0; i < 66; i++) step(0, 0, 0, 1, 20, 7'h11, "R3 wrap64");
    // R3 partial run on 1024 buffer, R4 interleave
    step(1, 21, 10'b1010110000, 0, 0, 0, "R3 setup1k");
    for (int i = 0; i < 40; i++) step(0, 0, 0, 1, (i % 2) ? 21 : 20, 7'h22, "R4 interleave");
    // R6 malformed with upper bits set, pointer held
    step(1, 22, 10'b1111100000, 0, 0, 0, "R6 setup");
    step(0, 0, 0, 1, 22, 7'h01, "R6 malformed");
    step(0, 0, 0, 1, 22, 7'h01, "R6 malformed again");
    // R7 same-cycle write and request
    step(0, 0, 0, 1, 20, 7'h03, "R7 pre");
    step(1, 20, 10'b0000000100, 1, 20, 7'h04, "R7 same cycle");
    step(0, 0, 0, 1, 20, 7'h05, "R7 after write");
    // R9 base changes per request
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 21, 7'(i * 13), "R9 base");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit we = ($urandom % 8) == 0;
      logic [9:0] f = 10'($urandom);
      if (($urandom % 10) == 0) f[4:0] = 0;
      step(we, $urandom % 32, f, ($urandom % 4) != 0, $urandom % 32,
           7'($urandom), "R4 random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule